// File: doc/BRIEF.md
# Up/Down Wiper Position Register

This block holds the tap position of each channel of a multi-channel digital potentiometer. Each channel keeps a 6-bit position and drives a registered one-hot tap-enable bus of 64 lines. Position 00h enables the tap at the low end of the resistor string. Position 3Fh enables the tap at the high end. A command sequencer outside the block decodes the serial protocol and sends strobes and data here. The sequencer can make a direct write from the host data byte, or a parallel load from one of four stored registers. That parallel load can target one channel, or both channels at once with a shared index. The sequencer can also open a step command of unbounded length. While that command is open, each serial clock pulse moves the selected channel's position one step. The step goes up when the serial input is high and down when it is low.

A small controller sequences the block through three states. `S_RECALL` is entered during reset. It loads every channel from its stored register 0 and then moves to `S_IDLE`. `S_IDLE` accepts direct writes and transfers. It moves to `S_STEP` when the step command opens. `S_STEP` applies step strobes and returns to `S_IDLE` when the command closes. The position of every channel is brought out for readback.

Top module: `wiper_pos_bank`

## Requirements
- R1: On the first clock edge after reset is released, each channel's position becomes the value of its stored register 0 (slice `(ch*4+0)*6 +: 6` of `store_vals`). While reset is held, every position reads 0.
- R2: `tap_en` for channel ch (slice `ch*64 +: 64`) always has exactly one bit set, at bit index equal to that channel's position. Position 00h sets bit 0 and position 3Fh sets bit 63. It changes on the same edge as the position.
- R3: In idle, a pulse on `host_wr` loads `host_data` into channel `host_ch` on the next edge. The other channel is unchanged.
- R4: In idle, a pulse on `xfer_go` with `xfer_all` low loads channel `xfer_ch` from its stored register `xfer_idx`. The other channel is unchanged.
- R5: In idle, a pulse on `xfer_go` with `xfer_all` high loads every channel, on the same edge, from that channel's own stored register `xfer_idx`.
- R6: While the step command is open, a pulse on `step_pulse` moves channel `step_ch` up one when `step_dir` is 1 and down one when it is 0. Other channels are unchanged.
- R7: Stepping saturates: up at 3Fh leaves 3Fh and down at 00h leaves 00h, with no wrap.
- R8: The step state is entered on the edge where `step_open` is seen high in idle, and it is left when `step_open` is seen low. Step pulses outside the step state have no effect. Writes and transfers inside the step state have no effect, and `step_open` in idle takes precedence over them.
- R9: When `host_wr` and `xfer_go` arrive in the same idle cycle, the direct write is performed and the transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| store_vals | input | 48 | Stored register contents, channel-major, 6 bits each |
| host_wr | input | 1 | Direct write strobe |
| host_ch | input | 1 | Channel for direct write |
| host_data | input | 6 | Direct write value |
| xfer_go | input | 1 | Stored-to-position transfer strobe |
| xfer_all | input | 1 | Transfer to all channels |
| xfer_ch | input | 1 | Channel for single transfer |
| xfer_idx | input | 2 | Stored register index for transfer |
| step_open | input | 1 | Step command is open |
| step_pulse | input | 1 | One step strobe per serial clock pulse |
| step_dir | input | 1 | Step direction, 1 = toward high end |
| step_ch | input | 1 | Channel that is stepped |
| pos | output | 12 | Positions for readback, channel ch at `ch*6 +: 6` |
| tap_en | output | 128 | Registered one-hot tap enables, channel ch at `ch*64 +: 64` |

## Verification
A wrong controller state shows up on the next edge. Either a write or transfer fails to land on `pos`, or a step pulse moves a position that should have held. If the decode drifts from the stored position, `tap_en` shows a bit away from the readback value, or two bits set, on the same edge as the update. A faulty saturation boundary shows within one step pulse at 00h or 3Fh, because the position wraps to the opposite end and the enabled tap jumps across the whole string.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
    typedef enum logic [1:0] {
        S_RECALL = 2'd0,
        S_IDLE   = 2'd1,
        S_STEP   = 2'd2
    } wpr_state_e;
endpackage

// File: rtl/wpr_ctrl.sv
module wpr_ctrl
    import wpr_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int NSTORE = 4,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int IW    = (NSTORE > 1) ? $clog2(NSTORE) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_wr,
    input  logic [CHW-1:0] host_ch,
    input  logic           xfer_go,
    input  logic           xfer_all,
    input  logic [CHW-1:0] xfer_ch,
    input  logic [IW-1:0]  xfer_idx,
    input  logic           step_open,
    input  logic           step_pulse,
    input  logic           step_dir,
    input  logic [CHW-1:0] step_ch,
    output logic [NCH-1:0] ld,
    output logic           use_host,
    output logic [IW-1:0]  sel_idx,
    output logic [NCH-1:0] inc,
    output logic [NCH-1:0] dec
);
    wpr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RECALL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        ld       = '0;
        inc      = '0;
        dec      = '0;
        use_host = 1'b0;
        sel_idx  = xfer_idx;
        unique case (state_q)
            S_RECALL: begin
                ld      = '1;
                sel_idx = '0;
                state_d = S_IDLE;
            end
            S_IDLE: begin
                if (step_open) begin
                    state_d = S_STEP;
                end else if (host_wr) begin
                    ld[host_ch] = 1'b1;
                    use_host    = 1'b1;
                end else if (xfer_go) begin
                    if (xfer_all) ld = '1;
                    else          ld[xfer_ch] = 1'b1;
                end
            end
            S_STEP: begin
                if (!step_open) begin
                    state_d = S_IDLE;
                end else if (step_pulse) begin
                    if (step_dir) inc[step_ch] = 1'b1;
                    else          dec[step_ch] = 1'b1;
                end
            end
            default: state_d = S_RECALL;
        endcase
    end

    p_recall_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_RECALL |=> state_q == S_IDLE);

    p_no_load_in_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_STEP |-> ld == '0);

    p_step_only_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc != '0 || dec != '0) |-> (state_q == S_STEP && step_open));

    p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({inc, dec}) <= 1);
endmodule

// File: rtl/wpr_chan.sv
module wpr_chan #(
    parameter int PW     = 6,
    parameter int NSTORE = 4,
    localparam int IW    = (NSTORE > 1) ? $clog2(NSTORE) : 1,
    localparam int NTAP  = 1 << PW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSTORE*PW-1:0] stored,
    input  logic               ld,
    input  logic               use_host,
    input  logic [PW-1:0]      host_data,
    input  logic [IW-1:0]      sel_idx,
    input  logic               inc,
    input  logic               dec,
    output logic [PW-1:0]      pos,
    output logic [NTAP-1:0]    tap
);
    localparam logic [PW-1:0] TOP = '1;

    logic [PW-1:0]   pos_q, pos_d;
    logic [NTAP-1:0] tap_q, tap_d;

    always_comb begin
        pos_d = pos_q;
        if (ld) begin
            pos_d = use_host ? host_data : stored[sel_idx*PW +: PW];
        end else if (inc && pos_q != TOP) begin
            pos_d = pos_q + 1'b1;
        end else if (dec && pos_q != '0) begin
            pos_d = pos_q - 1'b1;
        end
        tap_d        = '0;
        tap_d[pos_d] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            tap_q <= NTAP'(1);
        end else begin
            pos_q <= pos_d;
            tap_q <= tap_d;
        end
    end

    assign pos = pos_q;
    assign tap = tap_q;

    p_tap_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tap_q[pos_q] && $countones(tap_q) == 1);

    p_step_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && pos_q != TOP) |=> pos_q == $past(pos_q) + 1'b1);

    p_no_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && pos_q == TOP) |=> pos_q == TOP);

    p_no_wrap_bottom_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !ld && pos_q == '0) |=> pos_q == '0);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !inc && !dec) |=> $stable(pos_q));
endmodule

// File: rtl/wiper_pos_bank.sv
module wiper_pos_bank #(
    parameter int NCH    = 2,
    parameter int PW     = 6,
    parameter int NSTORE = 4,
    localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int IW    = (NSTORE > 1) ? $clog2(NSTORE) : 1,
    localparam int NTAP  = 1 << PW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH*NSTORE*PW-1:0]  store_vals,
    input  logic                      host_wr,
    input  logic [CHW-1:0]            host_ch,
    input  logic [PW-1:0]             host_data,
    input  logic                      xfer_go,
    input  logic                      xfer_all,
    input  logic [CHW-1:0]            xfer_ch,
    input  logic [IW-1:0]             xfer_idx,
    input  logic                      step_open,
    input  logic                      step_pulse,
    input  logic                      step_dir,
    input  logic [CHW-1:0]            step_ch,
    output logic [NCH*PW-1:0]         pos,
    output logic [NCH*NTAP-1:0]       tap_en
);
    logic [NCH-1:0] ld, inc, dec;
    logic           use_host;
    logic [IW-1:0]  sel_idx;

    wpr_ctrl #(.NCH(NCH), .NSTORE(NSTORE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_ch   (host_ch),
        .xfer_go   (xfer_go),
        .xfer_all  (xfer_all),
        .xfer_ch   (xfer_ch),
        .xfer_idx  (xfer_idx),
        .step_open (step_open),
        .step_pulse(step_pulse),
        .step_dir  (step_dir),
        .step_ch   (step_ch),
        .ld        (ld),
        .use_host  (use_host),
        .sel_idx   (sel_idx),
        .inc       (inc),
        .dec       (dec)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        wpr_chan #(.PW(PW), .NSTORE(NSTORE)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .stored   (store_vals[c*NSTORE*PW +: NSTORE*PW]),
            .ld       (ld[c]),
            .use_host (use_host),
            .host_data(host_data),
            .sel_idx  (sel_idx),
            .inc      (inc[c]),
            .dec      (dec[c]),
            .pos      (pos[c*PW +: PW]),
            .tap      (tap_en[c*NTAP +: NTAP])
        );
    end
endmodule

// File: tb/test_wiper_pos_bank.sv
module test_wiper_pos_bank;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] store_vals;
    logic        host_wr = 0, host_ch = 0;
    logic [5:0]  host_data = '0;
    logic        xfer_go = 0, xfer_all = 0, xfer_ch = 0;
    logic [1:0]  xfer_idx = '0;
    logic        step_open = 0, step_pulse = 0, step_dir = 0, step_ch = 0;
    logic [11:0] pos;
    logic [127:0] tap_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    wiper_pos_bank i_wiper_pos_bank (
        .clk(clk), .rst_n(rst_n), .store_vals(store_vals),
        .host_wr(host_wr), .host_ch(host_ch), .host_data(host_data),
        .xfer_go(xfer_go), .xfer_all(xfer_all), .xfer_ch(xfer_ch), .xfer_idx(xfer_idx),
        .step_open(step_open), .step_pulse(step_pulse), .step_dir(step_dir), .step_ch(step_ch),
        .pos(pos), .tap_en(tap_en)
    );

    task automatic set_store(int ch, int idx, logic [5:0] v);
        store_vals[(ch*4+idx)*6 +: 6] = v;
    endtask

    task automatic chk(string req, int ch, logic [5:0] exp);
        logic [5:0]  got  = pos[ch*6 +: 6];
        logic [63:0] gtap = tap_en[ch*64 +: 64];
        logic [63:0] etap = 64'(1) << exp;
        checks++;
        if (got !== exp || gtap !== etap) begin
            errors++;
            $display("FAIL %s ch%0d: pos=%h tap=%h expected pos=%h tap=%h",
                     req, ch, got, gtap, exp, etap);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0;
        tick();
        chk("R1", 0, 6'h00);
        chk("R2", 1, 6'h00);
        rst_n = 1;
        tick();
        chk("R1", 0, 6'h15);
        chk("R1", 1, 6'h07);
    endtask

    task automatic t_write();
        host_wr = 1; host_ch = 1; host_data = 6'h33;
        tick();
        host_wr = 0;
        chk("R3", 1, 6'h33);
        chk("R3", 0, 6'h15);
    endtask

    task automatic t_xfer();
        xfer_go = 1; xfer_all = 0; xfer_ch = 0; xfer_idx = 2'd1;
        tick();
        xfer_go = 0;
        chk("R4", 0, 6'h3E);
        chk("R4", 1, 6'h33);
    endtask

    task automatic t_global();
        xfer_go = 1; xfer_all = 1; xfer_idx = 2'd2;
        tick();
        xfer_go = 0; xfer_all = 0;
        chk("R5", 0, 6'h01);
        chk("R5 R2", 1, 6'h3F);
    endtask

    task automatic t_priority();
        host_wr = 1; host_ch = 0; host_data = 6'h20;
        xfer_go = 1; xfer_all = 1; xfer_idx = 2'd3;
        tick();
        host_wr = 0; xfer_go = 0; xfer_all = 0;
        chk("R9", 0, 6'h20);
        chk("R9", 1, 6'h3F);
    endtask

    task automatic pulse(logic ch, logic dir);
        step_pulse = 1; step_ch = ch; step_dir = dir;
        tick();
        step_pulse = 0;
    endtask

    task automatic t_step();
        step_open = 1;
        tick();
        for (int i = 0; i < 3; i++) pulse(0, 1);
        chk("R6", 0, 6'h23);
        pulse(0, 0);
        chk("R6", 0, 6'h22);
        chk("R6", 1, 6'h3F);
        pulse(1, 1);
        chk("R7", 1, 6'h3F);
        host_wr = 1; host_ch = 0; host_data = 6'h05;
        tick();
        host_wr = 0;
        chk("R8", 0, 6'h22);
        step_open = 0;
        tick();
    endtask

    task automatic t_floor();
        host_wr = 1; host_ch = 0; host_data = 6'h01;
        tick();
        host_wr = 0;
        step_open = 1;
        tick();
        for (int i = 0; i < 3; i++) pulse(0, 0);
        chk("R7 R2", 0, 6'h00);
        step_open = 0;
        tick();
    endtask

    task automatic t_ignore();
        pulse(1, 0);
        chk("R8", 1, 6'h3F);
        step_open = 1; host_wr = 1; host_ch = 1; host_data = 6'h0A;
        tick();
        host_wr = 0;
        chk("R8", 1, 6'h3F);
        step_open = 0;
        tick();
        t_reset();
    endtask

    initial begin
        store_vals = '0;
        set_store(0, 0, 6'h15); set_store(0, 1, 6'h3E); set_store(0, 2, 6'h01); set_store(0, 3, 6'h2A);
        set_store(1, 0, 6'h07); set_store(1, 1, 6'h00); set_store(1, 2, 6'h3F); set_store(1, 3, 6'h11);
        tick();
        t_reset();
        t_write();
        t_xfer();
        t_global();
        t_priority();
        t_step();
        t_floor();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(PERIOD*20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule